// File: doc/BRIEF.md
# Per-Thread Squash Request Filter

This block sits between the execute stage and the reorder buffer of a multithreaded out-of-order core. Every cycle, each thread may present a squash request that carries a sequence number, a flag that pulls the squashing instruction itself into the flush, branch outcome bits and two program counters. The filter decides whether the request is honoured, computes the flush boundary, and sends a registered broadcast back to the earlier stages one cycle later.

For each thread it records the youngest sequence number that is still valid. Dispatched instructions raise this mark and accepted squashes lower it. A request from an instruction younger than the mark is dropped, so a late squash from a younger instruction cannot override a flush that an older instruction has already started. A full-thread flush, used for traps and context changes, overrides the request path. The block counts the threads that are squashing and the accepted mispredicts, and it blocks retirement when every thread is squashing.

Top module: `squash_filter`

## Requirements
- R1: After reset every thread is running (squashing_o low), each youngest mark is 0, both counters are 0 and no broadcast is valid.
- R2: A squash request for thread t is accepted only when trap_pend_i[t] is low, flush_i[t] is low and sq_seq_i slice t is less than or equal to the thread's youngest mark (unsigned compare). Otherwise it has no effect.
- R3: The flush boundary of an accepted request is sq_seq_i minus one (modulo 2^SEQ_W) when sq_incl_i is set, and sq_seq_i otherwise.
- R4: On the clock edge that accepts a request, the thread's youngest mark becomes the boundary and the thread enters the squashing state. In the next cycle bc_vld_o is high with bc_done_seq_o equal to the boundary, and with bc_mispred_o, bc_taken_o, bc_next_pc_o and bc_bad_pc_o equal to the request's values.
- R5: done_sq_i[t] returns a squashing thread to running on the next edge, unless a new squash or flush is accepted in the same cycle. On a running thread it has no effect.
- R6: sq_cnt_o always equals the number of threads whose squashing_o is high.
- R7: flush_i[t] is always accepted and overrides a request in the same cycle. Its boundary is head_seq_i minus one, or 0 when rob_empty_i[t] is set. The youngest mark becomes 0. The broadcast carries mispredict 0, taken 0, next PC flush_pc_i and bad PC 0.
- R8: ins_o[t] (combinational) is high when disp_vld_i[t] is high, the thread is not squashing and no squash or flush is accepted for it in that cycle. An insert sets the youngest mark to disp_seq_i.
- R9: retire_block_o is high exactly when every thread is squashing.
- R10: mp_cnt_o (wrapping) increases by one for each accepted non-flush request that has sq_mispred_i set.
- R11: bc_vld_o is high only in the single cycle after an acceptance, and rob_sq_o[t] follows squashing_o[t].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sq_req_i | input | NUM_THR | Squash request per thread |
| sq_seq_i | input | NUM_THR*SEQ_W | Squashing sequence number per thread |
| sq_incl_i | input | NUM_THR | Include the squashing instruction in the flush |
| sq_mispred_i | input | NUM_THR | Branch mispredict flag |
| sq_taken_i | input | NUM_THR | Branch taken flag |
| sq_next_pc_i | input | NUM_THR*PC_W | Redirect PC |
| sq_bad_pc_i | input | NUM_THR*PC_W | PC of the mispredicted instruction |
| trap_pend_i | input | NUM_THR | Thread has a trap pending |
| flush_i | input | NUM_THR | Full-thread flush request |
| head_seq_i | input | NUM_THR*SEQ_W | Sequence number at the ROB head per thread |
| rob_empty_i | input | NUM_THR | ROB holds nothing for the thread |
| flush_pc_i | input | NUM_THR*PC_W | Restart PC for a full flush |
| disp_vld_i | input | NUM_THR | Dispatch offers an instruction |
| disp_seq_i | input | NUM_THR*SEQ_W | Sequence number of the dispatched instruction |
| done_sq_i | input | NUM_THR | ROB finished squashing the thread |
| ins_o | output | NUM_THR | Dispatch insert permitted |
| squashing_o | output | NUM_THR | Thread is in the squashing state |
| youngest_o | output | NUM_THR*SEQ_W | Youngest valid sequence mark per thread |
| bc_vld_o | output | NUM_THR | Squash broadcast valid |
| rob_sq_o | output | NUM_THR | ROB-squashing indication |
| bc_done_seq_o | output | NUM_THR*SEQ_W | Broadcast flush boundary |
| bc_mispred_o | output | NUM_THR | Broadcast mispredict flag |
| bc_taken_o | output | NUM_THR | Broadcast taken flag |
| bc_next_pc_o | output | NUM_THR*PC_W | Broadcast redirect PC |
| bc_bad_pc_o | output | NUM_THR*PC_W | Broadcast mispredicted PC |
| sq_cnt_o | output | $clog2(NUM_THR+1) | Number of threads squashing |
| mp_cnt_o | output | CNT_W | Accepted mispredict count |
| retire_block_o | output | 1 | Retirement blocked this cycle |

## Verification
Directed sequences first raise the youngest mark through dispatch. They then offer a squash just above the mark, one equal to it with the include flag, a request under a pending trap and a dispatch into a squashing thread. These separate the accept compare, the boundary decrement and the insert gate. Both threads are then made to squash at once to show retire blocking and the counter at its maximum. A flush with an empty and with a non-empty ROB, and a done pulse to a running thread, check the two flush boundaries and the ignore rule. Random traffic follows, with request sequence numbers placed on both sides of the mark and done, flush, trap and dispatch mixed in. It shows whether the accept decision, the counters and the broadcasts stay consistent when several events hit the same thread in one cycle.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  typedef enum logic {
    THR_RUN = 1'b0,
    THR_SQ  = 1'b1
  } thr_state_e;
endpackage

// File: rtl/sqf_thread.sv
module sqf_thread
  import sqf_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic             incl_i,
  input  logic             mispred_i,
  input  logic             taken_i,
  input  logic [PC_W-1:0]  npc_i,
  input  logic [PC_W-1:0]  bpc_i,
  input  logic             trap_i,
  input  logic             flush_i,
  input  logic [SEQ_W-1:0] head_i,
  input  logic             empty_i,
  input  logic [PC_W-1:0]  fpc_i,
  input  logic             disp_vld_i,
  input  logic [SEQ_W-1:0] disp_seq_i,
  input  logic             done_i,
  output logic             ins_o,
  output logic             squashing_o,
  output logic [SEQ_W-1:0] young_o,
  output logic             bc_vld_o,
  output logic [SEQ_W-1:0] bc_seq_o,
  output logic             bc_mp_o,
  output logic             bc_tk_o,
  output logic [PC_W-1:0]  bc_npc_o,
  output logic [PC_W-1:0]  bc_bpc_o,
  output logic             enter_o,
  output logic             leave_o,
  output logic             mp_evt_o
);
  thr_state_e       state_q;
  logic [SEQ_W-1:0] young_q;
  logic [SEQ_W-1:0] bnd_sq, bnd_fl;
  logic             sq_acc, acc, stay, sq_d;

  always_comb begin
    bnd_sq = incl_i ? seq_i - SEQ_W'(1) : seq_i;
    bnd_fl = empty_i ? '0 : head_i - SEQ_W'(1);
    sq_acc = !flush_i && req_i && !trap_i && (seq_i <= young_q);
    acc    = flush_i || sq_acc;
    stay   = (state_q == THR_SQ) && !done_i;
    sq_d   = acc || stay;
  end

  assign ins_o       = disp_vld_i && (state_q == THR_RUN) && !acc;
  assign squashing_o = (state_q == THR_SQ);
  assign young_o     = young_q;
  assign enter_o     = sq_d && (state_q == THR_RUN);
  assign leave_o     = !sq_d && (state_q == THR_SQ);
  assign mp_evt_o    = sq_acc && mispred_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= THR_RUN;
      young_q  <= '0;
      bc_vld_o <= 1'b0;
      bc_seq_o <= '0;
      bc_mp_o  <= 1'b0;
      bc_tk_o  <= 1'b0;
      bc_npc_o <= '0;
      bc_bpc_o <= '0;
    end else begin
      state_q  <= sq_d ? THR_SQ : THR_RUN;
      bc_vld_o <= acc;
      if (flush_i) begin
        young_q  <= '0;
        bc_seq_o <= bnd_fl;
        bc_mp_o  <= 1'b0;
        bc_tk_o  <= 1'b0;
        bc_npc_o <= fpc_i;
        bc_bpc_o <= '0;
      end else if (sq_acc) begin
        young_q  <= bnd_sq;
        bc_seq_o <= bnd_sq;
        bc_mp_o  <= mispred_i;
        bc_tk_o  <= taken_i;
        bc_npc_o <= npc_i;
        bc_bpc_o <= bpc_i;
      end else if (ins_o) begin
        young_q <= disp_seq_i;
      end
    end
  end

  assert_trap_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && trap_i && !flush_i) |=> !bc_vld_o);
  assert_no_insert_while_squash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squashing_o |-> !ins_o);
  assert_insert_updates_mark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |=> (young_o == $past(disp_seq_i)));
  assert_flush_clears_mark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (young_o == '0 && squashing_o && bc_vld_o && !bc_mp_o));
  assert_done_returns_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squashing_o && done_i && !req_i && !flush_i) |=> !squashing_o);
endmodule

// File: rtl/sqf_counter.sv
module sqf_counter #(
  parameter int NUM_THR = 2,
  parameter int CNT_W   = 8,
  localparam int SC_W   = $clog2(NUM_THR + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] enter_i,
  input  logic [NUM_THR-1:0] leave_i,
  input  logic [NUM_THR-1:0] mp_i,
  output logic [SC_W-1:0]    sq_cnt_o,
  output logic [CNT_W-1:0]   mp_cnt_o
);
  logic [SC_W-1:0]  n_in, n_out;
  logic [CNT_W-1:0] n_mp;

  always_comb begin
    n_in  = '0;
    n_out = '0;
    n_mp  = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      n_in  = n_in + SC_W'(enter_i[i]);
      n_out = n_out + SC_W'(leave_i[i]);
      n_mp  = n_mp + CNT_W'(mp_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_cnt_o <= '0;
      mp_cnt_o <= '0;
    end else begin
      sq_cnt_o <= sq_cnt_o + n_in - n_out;
      mp_cnt_o <= mp_cnt_o + n_mp;
    end
  end

  assert_no_enter_leave_same_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i & leave_i) == '0);
endmodule

// File: rtl/squash_filter.sv
module squash_filter
  import sqf_pkg::*;
#(
  parameter int NUM_THR = 2,
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 8,
  localparam int SC_W   = $clog2(NUM_THR + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_THR-1:0]       sq_req_i,
  input  logic [NUM_THR*SEQ_W-1:0] sq_seq_i,
  input  logic [NUM_THR-1:0]       sq_incl_i,
  input  logic [NUM_THR-1:0]       sq_mispred_i,
  input  logic [NUM_THR-1:0]       sq_taken_i,
  input  logic [NUM_THR*PC_W-1:0]  sq_next_pc_i,
  input  logic [NUM_THR*PC_W-1:0]  sq_bad_pc_i,
  input  logic [NUM_THR-1:0]       trap_pend_i,
  input  logic [NUM_THR-1:0]       flush_i,
  input  logic [NUM_THR*SEQ_W-1:0] head_seq_i,
  input  logic [NUM_THR-1:0]       rob_empty_i,
  input  logic [NUM_THR*PC_W-1:0]  flush_pc_i,
  input  logic [NUM_THR-1:0]       disp_vld_i,
  input  logic [NUM_THR*SEQ_W-1:0] disp_seq_i,
  input  logic [NUM_THR-1:0]       done_sq_i,
  output logic [NUM_THR-1:0]       ins_o,
  output logic [NUM_THR-1:0]       squashing_o,
  output logic [NUM_THR*SEQ_W-1:0] youngest_o,
  output logic [NUM_THR-1:0]       bc_vld_o,
  output logic [NUM_THR-1:0]       rob_sq_o,
  output logic [NUM_THR*SEQ_W-1:0] bc_done_seq_o,
  output logic [NUM_THR-1:0]       bc_mispred_o,
  output logic [NUM_THR-1:0]       bc_taken_o,
  output logic [NUM_THR*PC_W-1:0]  bc_next_pc_o,
  output logic [NUM_THR*PC_W-1:0]  bc_bad_pc_o,
  output logic [SC_W-1:0]          sq_cnt_o,
  output logic [CNT_W-1:0]         mp_cnt_o,
  output logic                     retire_block_o
);
  logic [NUM_THR-1:0] enter, leave, mp_evt;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    sqf_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_thr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (sq_req_i[t]),
      .seq_i      (sq_seq_i[t*SEQ_W +: SEQ_W]),
      .incl_i     (sq_incl_i[t]),
      .mispred_i  (sq_mispred_i[t]),
      .taken_i    (sq_taken_i[t]),
      .npc_i      (sq_next_pc_i[t*PC_W +: PC_W]),
      .bpc_i      (sq_bad_pc_i[t*PC_W +: PC_W]),
      .trap_i     (trap_pend_i[t]),
      .flush_i    (flush_i[t]),
      .head_i     (head_seq_i[t*SEQ_W +: SEQ_W]),
      .empty_i    (rob_empty_i[t]),
      .fpc_i      (flush_pc_i[t*PC_W +: PC_W]),
      .disp_vld_i (disp_vld_i[t]),
      .disp_seq_i (disp_seq_i[t*SEQ_W +: SEQ_W]),
      .done_i     (done_sq_i[t]),
      .ins_o      (ins_o[t]),
      .squashing_o(squashing_o[t]),
      .young_o    (youngest_o[t*SEQ_W +: SEQ_W]),
      .bc_vld_o   (bc_vld_o[t]),
      .bc_seq_o   (bc_done_seq_o[t*SEQ_W +: SEQ_W]),
      .bc_mp_o    (bc_mispred_o[t]),
      .bc_tk_o    (bc_taken_o[t]),
      .bc_npc_o   (bc_next_pc_o[t*PC_W +: PC_W]),
      .bc_bpc_o   (bc_bad_pc_o[t*PC_W +: PC_W]),
      .enter_o    (enter[t]),
      .leave_o    (leave[t]),
      .mp_evt_o   (mp_evt[t])
    );
  end

  sqf_counter #(.NUM_THR(NUM_THR), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (enter),
    .leave_i (leave),
    .mp_i    (mp_evt),
    .sq_cnt_o(sq_cnt_o),
    .mp_cnt_o(mp_cnt_o)
  );

  assign rob_sq_o       = squashing_o;
  assign retire_block_o = &squashing_o;

  assert_cnt_matches_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sq_cnt_o) == $countones(squashing_o));
  assert_retire_block_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_block_o |-> (32'(sq_cnt_o) == NUM_THR));
  assert_bcast_one_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_vld_o != '0) |-> ((bc_vld_o & squashing_o) == bc_vld_o));
endmodule

// File: tb/tb_squash_filter.sv
`timescale 1ns/1ps
module tb_squash_filter;
  localparam int T  = 2;
  localparam int SW = 16;
  localparam int PW = 32;
  localparam int CW = 8;
  localparam int SCW = $clog2(T + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic [T-1:0]    req, incl, mp, tk, trap, flush, empty, dvld, done;
  logic [T*SW-1:0] seqv, headv, dseqv;
  logic [T*PW-1:0] npcv, bpcv, fpcv;
  logic [T-1:0]    ins_o, squashing_o, bc_vld_o, rob_sq_o, bc_mispred_o, bc_taken_o;
  logic [T*SW-1:0] youngest_o, bc_done_seq_o;
  logic [T*PW-1:0] bc_next_pc_o, bc_bad_pc_o;
  logic [SCW-1:0]  sq_cnt_o;
  logic [CW-1:0]   mp_cnt_o;
  logic            retire_block_o;

  squash_filter #(.NUM_THR(T), .SEQ_W(SW), .PC_W(PW), .CNT_W(CW)) dut (
    .clk_i, .rst_ni,
    .sq_req_i(req), .sq_seq_i(seqv), .sq_incl_i(incl), .sq_mispred_i(mp),
    .sq_taken_i(tk), .sq_next_pc_i(npcv), .sq_bad_pc_i(bpcv),
    .trap_pend_i(trap), .flush_i(flush), .head_seq_i(headv),
    .rob_empty_i(empty), .flush_pc_i(fpcv), .disp_vld_i(dvld),
    .disp_seq_i(dseqv), .done_sq_i(done),
    .ins_o, .squashing_o, .youngest_o, .bc_vld_o, .rob_sq_o, .bc_done_seq_o,
    .bc_mispred_o, .bc_taken_o, .bc_next_pc_o, .bc_bad_pc_o,
    .sq_cnt_o, .mp_cnt_o, .retire_block_o
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic          m_sq  [T];
  logic [SW-1:0] m_yg  [T];
  logic          m_bc  [T];
  logic [SW-1:0] m_bseq[T];
  logic          m_bmp [T];
  logic          m_btk [T];
  logic [PW-1:0] m_npc [T];
  logic [PW-1:0] m_bpc [T];
  logic [CW-1:0] m_mpc;

  task automatic chk(string req_tag, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req_tag, what, got, exp);
    end
  endtask

  task automatic clr();
    req = '0; incl = '0; mp = '0; tk = '0; trap = '0; flush = '0; empty = '0;
    dvld = '0; done = '0; seqv = '0; headv = '0; dseqv = '0;
    npcv = '0; bpcv = '0; fpcv = '0;
  endtask

  function automatic int count_sq();
    int c = 0;
    for (int t = 0; t < T; t++) c += int'(m_sq[t]);
    return c;
  endfunction

  task automatic check_state();
    for (int t = 0; t < T; t++) begin
      chk("R4", "squashing", 64'(squashing_o[t]), 64'(m_sq[t]));
      chk("R8", "youngest", 64'(youngest_o[t*SW +: SW]), 64'(m_yg[t]));
      chk("R11", "bc_vld", 64'(bc_vld_o[t]), 64'(m_bc[t]));
      chk("R11", "rob_sq", 64'(rob_sq_o[t]), 64'(m_sq[t]));
      if (m_bc[t]) begin
        chk("R4", "bc_done_seq", 64'(bc_done_seq_o[t*SW +: SW]), 64'(m_bseq[t]));
        chk("R4", "bc_mispred", 64'(bc_mispred_o[t]), 64'(m_bmp[t]));
        chk("R4", "bc_taken", 64'(bc_taken_o[t]), 64'(m_btk[t]));
        chk("R7", "bc_next_pc", 64'(bc_next_pc_o[t*PW +: PW]), 64'(m_npc[t]));
        chk("R7", "bc_bad_pc", 64'(bc_bad_pc_o[t*PW +: PW]), 64'(m_bpc[t]));
      end
    end
    chk("R6", "sq_cnt", 64'(sq_cnt_o), 64'(count_sq()));
    chk("R10", "mp_cnt", 64'(mp_cnt_o), 64'(m_mpc));
  endtask

  // inputs already driven (after a negedge); check comb outputs, advance model
  task automatic step();
    logic a_fl, a_sq, exp_ins;
    logic [SW-1:0] s, b;
    #1;
    chk("R9", "retire_block", 64'(retire_block_o), 64'(count_sq() == T));
    for (int t = 0; t < T; t++) begin
      s = seqv[t*SW +: SW];
      a_fl = flush[t];
      a_sq = !flush[t] && req[t] && !trap[t] && (s <= m_yg[t]);
      exp_ins = dvld[t] && !m_sq[t] && !(a_fl || a_sq);
      chk("R8", "ins", 64'(ins_o[t]), 64'(exp_ins));
      m_sq[t] = a_fl || a_sq || (m_sq[t] && !done[t]);
      m_bc[t] = a_fl || a_sq;
      if (a_fl) begin
        m_bseq[t] = empty[t] ? '0 : headv[t*SW +: SW] - 1'b1;
        m_yg[t] = '0; m_bmp[t] = 0; m_btk[t] = 0;
        m_npc[t] = fpcv[t*PW +: PW]; m_bpc[t] = '0;
      end else if (a_sq) begin
        b = incl[t] ? s - 1'b1 : s;
        m_bseq[t] = b; m_yg[t] = b; m_bmp[t] = mp[t]; m_btk[t] = tk[t];
        m_npc[t] = npcv[t*PW +: PW]; m_bpc[t] = bpcv[t*PW +: PW];
        if (mp[t]) m_mpc = m_mpc + 1'b1;
      end else if (exp_ins) begin
        m_yg[t] = dseqv[t*SW +: SW];
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check_state();
  endtask

  task automatic sq(int t, int s, bit inc, bit mpf, bit tkf);
    req[t] = 1; seqv[t*SW +: SW] = SW'(s); incl[t] = inc; mp[t] = mpf; tk[t] = tkf;
    npcv[t*PW +: PW] = PW'(32'h1000 + s); bpcv[t*PW +: PW] = PW'(32'h2000 + s);
  endtask

  task automatic rand_vec();
    clr();
    for (int t = 0; t < T; t++) begin
      if ($urandom_range(3) == 0) begin
        int d = $urandom_range(10);
        sq(t, int'(m_yg[t]) + d - 6, $urandom_range(1) == 1, $urandom_range(1) == 1,
           $urandom_range(1) == 1);
      end
      trap[t]  = ($urandom_range(7) == 0);
      flush[t] = ($urandom_range(15) == 0);
      empty[t] = ($urandom_range(1) == 1);
      headv[t*SW +: SW] = SW'($urandom_range(200));
      fpcv[t*PW +: PW]  = $urandom;
      done[t]  = ($urandom_range(2) == 0);
      dvld[t]  = ($urandom_range(1) == 1);
      dseqv[t*SW +: SW] = m_yg[t] + SW'($urandom_range(3) + 1);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clr();
    for (int t = 0; t < T; t++) begin
      m_sq[t] = 0; m_yg[t] = '0; m_bc[t] = 0; m_bseq[t] = '0;
      m_bmp[t] = 0; m_btk[t] = 0; m_npc[t] = '0; m_bpc[t] = '0;
    end
    m_mpc = '0;
    repeat (3) @(negedge clk_i);
    check_state();   // R1 reset state
    chk("R1", "retire_block reset", 64'(retire_block_o), 64'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8: raise thread 0 mark to 10
    clr(); dvld[0] = 1; dseqv[0 +: SW] = 10; step();
    // R2: request above the mark is dropped
    clr(); sq(0, 12, 0, 1, 0); step();
    // R3: include flag gives boundary 9, R10 mispredict counted
    clr(); sq(0, 10, 1, 1, 1); step();
    // R8: dispatch into squashing thread is blocked
    clr(); dvld[0] = 1; dseqv[0 +: SW] = 11; step();
    // R2: trap pending blocks an otherwise valid request on thread 1
    clr(); sq(1, 0, 0, 0, 0); trap[1] = 1; step();
    // R9: thread 1 squashes too, both squashing
    clr(); sq(1, 0, 0, 1, 0); step();
    clr(); step();
    // R5: both done
    clr(); done = '1; step();
    // R5: done on running thread ignored
    clr(); done[0] = 1; step();
    // R7: flush, empty and non-empty; request overridden
    clr(); flush = '1; empty[1] = 1; headv[0 +: SW] = 20; fpcv[0 +: PW] = 32'hABCD;
    sq(0, 0, 0, 1, 1); step();
    clr(); done = '1; step();

    for (int i = 0; i < 3000; i++) begin
      rand_vec();
      step();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule